// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block watches two reference clocks, a primary and a backup, from a free-running monitor clock and decides which of them should feed a downstream PLL. Each reference is sampled through a two-flop synchronizer. A window counter checks that rising edges keep arriving. A reference that goes quiet is marked bad, and it is marked good again only after it has shown edges in several windows in a row.

A selection controller drives the select line of an external clock multiplexer and an active-clock indicator. It has three operating policies. In the automatic policy, it fails over when the reference in use goes bad. In the manual policy, it toggles on a qualified switch request. In the combined policy, both triggers apply. A request counts only after it has been held high for a minimum number of monitor cycles. A programmable delay of 0 to 7 cycles can be placed between the trigger and the change of selection. The controller never moves the selection onto a reference that is currently marked bad.

Top module: `refsw_ctrl`

## Requirements
- R1: `active_o` is 0 while the primary reference is in use and 1 while the backup is in use. It follows `mux_sel_o` one monitor cycle later.
- R2: A reference whose rising edges stop gets its bad flag (`bad0_o` or `bad1_o`) set within 2 aligned 16-cycle windows plus 3 cycles. A flag stays 0 while its reference keeps toggling.
- R3: A bad flag returns to 0 only after 4 consecutive 16-cycle windows that each contain a rising edge. It is still 1 twenty cycles after the reference restarts.
- R4: `sw_req_i` qualifies only when it is high on at least 3 consecutive monitor edges. A shorter pulse has no effect, and one high period yields at most one switch.
- R5: With delay D on `sw_dly_i`, a manual switch appears on `mux_sel_o` 3+D edges after the first edge that samples the request high. An automatic switch appears 1+D edges after the edge that sets the bad flag.
- R6: Mode encoding on `mode_i`: 0 is automatic, 1 is manual, 2 is automatic with manual override, and 3 behaves as 0. In modes 0 and 3 a qualified request is ignored.
- R7: In automatic operation, when the reference in use is flagged bad and the other is good, the selection moves to the other reference. It does not move back when the failed reference recovers.
- R8: In manual mode, each qualified request toggles the selection. The failure of the reference in use does not cause a switch.
- R9: In override mode, a qualified request switches the selection even when both references are good, and automatic failover still applies.
- R10: The selection never changes to a reference whose bad flag is set at the moment of the switch.
- R11: During and after reset, `mux_sel_o`, `active_o`, `bad0_o` and `bad1_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running monitor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref0_i | input | 1 | Primary reference clock (monitored as data) |
| ref1_i | input | 1 | Backup reference clock (monitored as data) |
| mode_i | input | 2 | Switchover policy: 0 auto, 1 manual, 2 auto with override, 3 as auto |
| sw_dly_i | input | 3 | Cycles of delay inserted before a switch is applied |
| sw_req_i | input | 1 | Manual switch request, synchronous to clk_i |
| bad0_o | output | 1 | Primary reference stopped |
| bad1_o | output | 1 | Backup reference stopped |
| active_o | output | 1 | Reference currently in use (0 primary, 1 backup) |
| mux_sel_o | output | 1 | Select line for the external clock multiplexer |

## Verification
A detector window counter or good-window counter that drifts shows up as a bad flag that rises or clears too early or too late. The bench sees this within a few windows of a reference stopping or restarting. A wrong request qualifier or delay counter moves `mux_sel_o` on the wrong edge, and the bench checks the selection on the edge just before the expected switch and on the edge of the switch itself. A wrong policy decode shows up as a switch that should not happen, or a missing one, within one request or one failure event.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO     = 2'd0,
    MODE_MANUAL   = 2'd1,
    MODE_AUTO_OVR = 2'd2,
    MODE_RSVD     = 2'd3
  } sw_mode_e;

  localparam int unsigned NUM_REFS = 2;
endpackage

// File: rtl/refsw_loss_det.sv
module refsw_loss_det #(
  parameter int unsigned WIN_CYCLES   = 16,
  parameter int unsigned GOOD_WINDOWS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic bad_o
);
  localparam int unsigned CW = $clog2(WIN_CYCLES);
  localparam int unsigned GW = $clog2(GOOD_WINDOWS + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] win_q;
  logic [GW-1:0] good_q;
  logic          seen_q, bad_q;
  logic          rise, win_end, hit;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign win_end = (win_q == CW'(WIN_CYCLES - 1));
  assign hit     = seen_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      win_q  <= '0;
      good_q <= '0;
      seen_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ref_i};
      win_q  <= win_end ? '0 : win_q + 1'b1;
      if (win_end) begin
        seen_q <= 1'b0;
        if (!hit) begin
          bad_q  <= 1'b1;
          good_q <= '0;
        end else if (bad_q) begin
          if (good_q == GW'(GOOD_WINDOWS - 1)) begin
            bad_q  <= 1'b0;
            good_q <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
      end else begin
        seen_q <= hit;
      end
    end
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/refsw_req_qual.sv
module refsw_req_qual #(
  parameter int unsigned MIN_HIGH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(MIN_HIGH + 1);

  logic [CW-1:0] cnt_q;

  // fires once, on the edge that completes the minimum high run
  assign pulse_o = req_i && (cnt_q == CW'(MIN_HIGH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!req_i)                  cnt_q <= '0;
    else if (cnt_q != CW'(MIN_HIGH))  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refsw_sel_ctrl.sv
module refsw_sel_ctrl
  import refsw_pkg::*;
#(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [1:0]       bad_i,
  input  logic             man_pulse_i,
  output logic             sel_o,
  output logic             active_o
);
  logic             sel_q, act_q, pend_q;
  logic [DLY_W-1:0] dcnt_q;
  logic             cur_bad, oth_bad, auto_en, man_en, trig;

  assign cur_bad = bad_i[sel_q];
  assign oth_bad = bad_i[~sel_q];
  assign auto_en = (mode_i != MODE_MANUAL);
  assign man_en  = (mode_i == MODE_MANUAL) || (mode_i == MODE_AUTO_OVR);
  assign trig    = !pend_q && !oth_bad &&
                   ((auto_en && cur_bad) || (man_en && man_pulse_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else begin
      act_q <= sel_q;
      if (pend_q) begin
        if (dcnt_q == DLY_W'(1)) begin
          pend_q <= 1'b0;
          if (!oth_bad) sel_q <= ~sel_q;  // target went bad meanwhile: drop
        end else begin
          dcnt_q <= dcnt_q - 1'b1;
        end
      end else if (trig) begin
        if (dly_i == '0) sel_q <= ~sel_q;
        else             pend_q <= 1'b1;
        dcnt_q <= dly_i;
      end
    end
  end

  assign sel_o    = sel_q;
  assign active_o = act_q;
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int unsigned WIN_CYCLES   = 16,
  parameter int unsigned GOOD_WINDOWS = 4,
  parameter int unsigned REQ_MIN      = 3,
  parameter int unsigned DLY_W        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref0_i,
  input  logic             ref1_i,
  input  logic [1:0]       mode_i,
  input  logic [DLY_W-1:0] sw_dly_i,
  input  logic             sw_req_i,
  output logic             bad0_o,
  output logic             bad1_o,
  output logic             active_o,
  output logic             mux_sel_o
);
  logic [NUM_REFS-1:0] refs, bad;
  logic                man_pulse;

  assign refs = {ref1_i, ref0_i};

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_det
    refsw_loss_det #(
      .WIN_CYCLES  (WIN_CYCLES),
      .GOOD_WINDOWS(GOOD_WINDOWS)
    ) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ref_i (refs[g]),
      .bad_o (bad[g])
    );
  end

  refsw_req_qual #(.MIN_HIGH(REQ_MIN)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (sw_req_i),
    .pulse_o(man_pulse)
  );

  refsw_sel_ctrl #(.DLY_W(DLY_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .dly_i      (sw_dly_i),
    .bad_i      (bad),
    .man_pulse_i(man_pulse),
    .sel_o      (mux_sel_o),
    .active_o   (active_o)
  );

  assign bad0_o = bad[0];
  assign bad1_o = bad[1];
endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_req_i,
  input logic man_pulse,
  input logic bad0_o,
  input logic bad1_o,
  input logic active_o,
  input logic mux_sel_o
);
  p_active_lag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == $past(mux_sel_o));

  p_qual_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_pulse |-> (sw_req_i && $past(sw_req_i) && $past(sw_req_i, 2)));

  p_no_bad_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o != $past(mux_sel_o)) |->
      ($past(mux_sel_o) ? !$past(bad0_o) : !$past(bad1_o)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r11: assert (!mux_sel_o && !active_o && !bad0_o && !bad1_o);
    end
  end
endmodule

bind refsw_ctrl refsw_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sw_req_i (sw_req_i),
  .man_pulse(man_pulse),
  .bad0_o   (bad0_o),
  .bad1_o   (bad1_o),
  .active_o (active_o),
  .mux_sel_o(mux_sel_o)
);

// File: tb/sim_refsw_ctrl.sv
`timescale 1ns/1ps
module sim_refsw_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       r0 = 0, r1 = 0, en0 = 1, en1 = 1;
  logic [1:0] mode = 2'd0;
  logic [2:0] dly = 3'd0;
  logic       req = 0;
  logic       bad0, bad1, act, sel;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // scoreboard queues: {bad1,bad0,active,sel}
  string      q_tag[$];
  logic [3:0] q_msk[$];
  logic [3:0] q_val[$];

  always #5 clk = ~clk;
  always #15 r0 <= en0 ? ~r0 : 1'b0;
  always #23 r1 <= en1 ? ~r1 : 1'b0;

  refsw_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref0_i(r0), .ref1_i(r1),
    .mode_i(mode), .sw_dly_i(dly), .sw_req_i(req),
    .bad0_o(bad0), .bad1_o(bad1), .active_o(act), .mux_sel_o(sel)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [3:0] msk, input logic [3:0] val);
    q_tag.push_back(tag);
    q_msk.push_back(msk);
    q_val.push_back(val);
  endtask

  // monitor: pops and compares against the port values
  always @(negedge clk) begin
    while (q_tag.size() > 0) begin
      string t;
      logic [3:0] m, v, a;
      t = q_tag.pop_front();
      m = q_msk.pop_front();
      v = q_val.pop_front();
      a = {bad1, bad0, act, sel};
      n_cmp++;
      if ((a & m) !== (v & m)) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b (mask %b)", t, a & m, v & m, m);
      end
    end
  end

  task automatic pulse_req(input int n);
    req = 1;
    step(n);
    req = 0;
  endtask

  initial begin
    step(5);
    expect_out("R11 reset state", 4'b1111, 4'b0000);
    rst_n = 1;
    step(100);
    expect_out("R2 running refs not flagged", 4'b1111, 4'b0000);

    // automatic failover with delay 2
    dly = 3'd2;
    en0 = 0;
    begin
      int w = 0;
      while (!bad0 && w < 60) begin step(1); w++; end
      expect_out($sformatf("R2 detect time %0d<=40", w), 4'b0000, 4'b0000);
      if (w > 40) begin n_bad++; $display("FAIL R2: detect %0d expected <=40", w); end
    end
    expect_out("R5 auto before delay", 4'b0101, 4'b0100);
    step(2);
    expect_out("R5 auto edge D", 4'b0001, 4'b0000);
    step(1);
    expect_out("R7 auto switched", 4'b0001, 4'b0001);
    step(1);
    expect_out("R1 active follows", 4'b0011, 4'b0011);

    en0 = 1;
    step(20);
    expect_out("R3 still bad early", 4'b0100, 4'b0100);
    step(80);
    expect_out("R3 recovered, R7 no revert", 4'b0111, 4'b0011);

    // manual mode
    mode = 2'd1; dly = 3'd0;
    pulse_req(2);
    step(10);
    expect_out("R4 short req ignored", 4'b0001, 4'b0001);
    req = 1;
    step(2);
    expect_out("R4 before qualify", 4'b0001, 4'b0001);
    step(1);
    expect_out("R8 manual toggle", 4'b0001, 4'b0000);
    step(5);
    expect_out("R4 one switch per high", 4'b0001, 4'b0000);
    req = 0;
    step(3);

    dly = 3'd3;
    req = 1;
    step(3);
    req = 0;
    step(2);
    expect_out("R5 manual 2+D", 4'b0001, 4'b0000);
    step(1);
    expect_out("R5 manual 3+D", 4'b0001, 4'b0001);
    dly = 3'd0;

    en1 = 0;
    step(60);
    expect_out("R8 no auto in manual", 4'b1001, 4'b1001);
    pulse_req(3);
    step(2);
    expect_out("R8 manual to good ref", 4'b0001, 4'b0000);
    pulse_req(3);
    step(10);
    expect_out("R10 no switch to bad", 4'b1001, 4'b1000);
    en1 = 1;
    step(100);
    expect_out("R3 backup recovered", 4'b1000, 4'b0000);

    // override mode
    mode = 2'd2;
    pulse_req(3);
    step(2);
    expect_out("R9 override switch", 4'b0001, 4'b0001);
    en1 = 0;
    step(45);
    expect_out("R9 failover in override", 4'b1001, 4'b1000);
    en1 = 1;
    step(100);

    // auto: request ignored; mode 3 acts as auto
    mode = 2'd0;
    pulse_req(3);
    step(10);
    expect_out("R6 req ignored in auto", 4'b0001, 4'b0000);
    mode = 2'd3;
    en0 = 0;
    step(45);
    expect_out("R6 mode 3 failover", 4'b0101, 4'b0101);
    en0 = 1;
    step(100);

    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule